// File: doc/BRIEF.md
# Atomic Micro-Op Decomposition Sequencer

This block sits in the decode stage of a small in-order RISC pipeline. It takes one decoded instruction at a time and emits a stream of micro-ops, one per clock. Each micro-op has an operation code, a destination id, a source id, an immediate, the PC of the instruction it came from, and a flag that marks the last micro-op of that instruction. Instructions that change more than one piece of architectural state are split into ordered steps. Every such instruction then becomes idempotent: if a rollback re-executes it from its first step, the result is the same.

Two instruction classes are split. A post-increment load becomes the memory load, followed by a separate update of the address register. A return-from-exception first copies the stack pointer into a shadow temporary. It then computes the new stack pointer and the restore address into further temporaries, restores the status register from memory, writes the new stack pointer, and loads the PC from memory as the very last step. All other instructions pass through as one micro-op. While further micro-ops of an instruction remain, the block stalls fetch. A flush input abandons the sequence in progress at once.

Top module: `uop_split_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it, uopValid, uopLast and stallFetch are all 0.
- R2: An instruction of class 0 or 3 (plain) that is accepted in cycle N appears in cycle N+1 as one micro-op. It has op PASS (0), destination {0,inRn}, source {0,inRm}, immediate 0 and uopLast=1, and stallFetch stays 0.
- R3: A class 1 instruction (post-increment load) with inRn different from inRm produces two micro-ops, in this order. The first is LOAD (op 3) with destination {0,Rn}, source {0,Rm} and immediate 0. The second is ADDI (op 2) with destination and source {0,Rm}, immediate ACCESS_BYTES and uopLast=1.
- R4: A class 1 instruction with inRn equal to inRm produces only the LOAD micro-op, with uopLast=1. No address update is issued.
- R5: A class 2 instruction (return-from-exception) produces six micro-ops, in this order. MOV (op 1) TMP1 from R15. ADDI TMP2 from R15 plus 2*ACCESS_BYTES. ADDI TMP3 from TMP1 plus ACCESS_BYTES. LOAD SR from address TMP3. MOV R15 from TMP2. LOAD PC from address TMP1, with uopLast=1. The ids are: TMP1=16, TMP2=17, TMP3=18, SR=30, PC=31, and R15=15.
- R6: A micro-op whose destination is the PC (id 31) always has uopLast=1.
- R7: Every micro-op carries the inPc value of its parent instruction. stallFetch is 1 exactly while the micro-op on the output is not the last one. An instruction is accepted only when inValid=1, stallFetch=0 and flush=0. Inputs offered while stallFetch=1 have no effect.
- R8: A flush that is sampled at a clock edge gives uopValid=0 and stallFetch=0 in the next cycle. The instruction offered in that cycle is dropped. The next instruction that is accepted starts from its first micro-op.
- R9: An instruction that is offered while the last micro-op of the previous instruction is on the output is accepted in that cycle, and its first micro-op follows in the next cycle with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Abandon the current sequence and clear the held instruction |
| inValid | input | 1 | A decoded instruction is offered |
| inClass | input | 2 | Instruction class: 0 plain, 1 post-increment load, 2 return-from-exception, 3 plain |
| inRn | input | 4 | Destination register number |
| inRm | input | 4 | Source or address register number |
| inPc | input | PC_W | PC of the offered instruction |
| stallFetch | output | 1 | Hold fetch; further micro-ops remain |
| uopValid | output | 1 | A micro-op is presented |
| uopOp | output | 2 | Micro-op code: 0 PASS, 1 MOV, 2 ADDI, 3 LOAD |
| uopDst | output | 5 | Destination id |
| uopSrc | output | 5 | Source or address id |
| uopImm | output | IMM_W | Immediate added to the source |
| uopPc | output | PC_W | PC of the parent instruction |
| uopLast | output | 1 | Final micro-op of the parent instruction |

## Verification
Plain instructions show whether the pass-through path adds a cycle or a stall. Post-increment loads are run with distinct registers and with the same register. Comparing the two shows whether the address update follows the load, and whether it is suppressed when it would overwrite the loaded value. Return-from-exception is run alone and with the next instruction held on the input, which separates correct step order and PC-last placement from a lost or duplicated back-to-back acceptance. Flushes dropped in the middle of a sequence, and a long stretch of mixed traffic, show whether a new instruction always restarts at its first step.

// File: rtl/uop_seq_pkg.sv
package uop_seq_pkg;

  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_MOV  = 2'd1,
    OP_ADDI = 2'd2,
    OP_LOAD = 2'd3
  } uop_op_e;

  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_LDINC = 2'd1,
    CLS_RTE   = 2'd2,
    CLS_RSVD  = 2'd3
  } instr_cls_e;

  localparam int REG_ID_W = 5;
  localparam int STEP_W   = 3;
  localparam int RTE_UOPS = 6;

  localparam logic [REG_ID_W-1:0] ID_SP   = 5'd15;
  localparam logic [REG_ID_W-1:0] ID_TMP1 = 5'd16;
  localparam logic [REG_ID_W-1:0] ID_TMP2 = 5'd17;
  localparam logic [REG_ID_W-1:0] ID_TMP3 = 5'd18;
  localparam logic [REG_ID_W-1:0] ID_SR   = 5'd30;
  localparam logic [REG_ID_W-1:0] ID_PC   = 5'd31;

  // strobes from sequence control to datapath
  typedef struct packed {
    logic capture;
    logic clear;
  } seq_strobe_t;

endpackage

// File: rtl/uop_seq_ctrl.sv
module uop_seq_ctrl
  import uop_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              inValid,
  input  logic [1:0]        inClass,
  input  logic [3:0]        inRn,
  input  logic [3:0]        inRm,
  output seq_strobe_t       seqStb,
  output logic              active,
  output logic [STEP_W-1:0] step,
  output logic              isLast,
  output logic              stallFetch
);

  logic [STEP_W-1:0] lastStep;
  logic [STEP_W-1:0] seqLen;
  logic              accept;

  // number of micro-ops for the offered instruction
  always_comb begin
    case (inClass)
      CLS_LDINC: seqLen = (inRn == inRm) ? STEP_W'(1) : STEP_W'(2);
      CLS_RTE:   seqLen = STEP_W'(RTE_UOPS);
      default:   seqLen = STEP_W'(1);
    endcase
  end

  assign isLast     = active && (step == lastStep);
  assign stallFetch = active && !isLast;
  assign accept     = inValid && !stallFetch && !flush;

  assign seqStb.capture = accept;
  assign seqStb.clear   = flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      step     <= '0;
      lastStep <= '0;
    end else if (flush) begin
      active   <= 1'b0;
      step     <= '0;
      lastStep <= '0;
    end else if (accept) begin
      active   <= 1'b1;
      step     <= '0;
      lastStep <= seqLen - STEP_W'(1);
    end else if (isLast) begin
      active   <= 1'b0;
    end else if (active) begin
      step     <= step + STEP_W'(1);
    end
  end

  // R8
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!active && !stallFetch));

  // R7
  stall_progress_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stallFetch && !flush) |=> (active && step == $past(step) + STEP_W'(1)));

  // R9
  refill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isLast && inValid && !flush) |=> (active && step == '0));

endmodule

// File: rtl/uop_seq_dpath.sv
module uop_seq_dpath
  import uop_seq_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int IMM_W        = 8,
  parameter int ACCESS_BYTES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         seqStb,
  input  logic                active,
  input  logic                isLast,
  input  logic [STEP_W-1:0]   step,
  input  logic [1:0]          inClass,
  input  logic [3:0]          inRn,
  input  logic [3:0]          inRm,
  input  logic [PC_W-1:0]     inPc,
  output logic                uopValid,
  output logic [1:0]          uopOp,
  output logic [REG_ID_W-1:0] uopDst,
  output logic [REG_ID_W-1:0] uopSrc,
  output logic [IMM_W-1:0]    uopImm,
  output logic [PC_W-1:0]     uopPc,
  output logic                uopLast
);

  localparam logic [IMM_W-1:0] IMM_WORD  = IMM_W'(ACCESS_BYTES);
  localparam logic [IMM_W-1:0] IMM_FRAME = IMM_W'(2 * ACCESS_BYTES);

  logic [1:0]      heldCls;
  logic [3:0]      heldRn;
  logic [3:0]      heldRm;
  logic [PC_W-1:0] heldPc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldCls <= '0;
      heldRn  <= '0;
      heldRm  <= '0;
      heldPc  <= '0;
    end else if (seqStb.clear) begin
      heldCls <= '0;
      heldRn  <= '0;
      heldRm  <= '0;
      heldPc  <= '0;
    end else if (seqStb.capture) begin
      heldCls <= inClass;
      heldRn  <= inRn;
      heldRm  <= inRm;
      heldPc  <= inPc;
    end
  end

  logic [REG_ID_W-1:0] gprN;
  logic [REG_ID_W-1:0] gprM;
  assign gprN = {1'b0, heldRn};
  assign gprM = {1'b0, heldRm};

  always_comb begin
    uopOp  = OP_PASS;
    uopDst = '0;
    uopSrc = '0;
    uopImm = '0;
    if (active) begin
      case (heldCls)
        CLS_LDINC: begin
          if (step == STEP_W'(0)) begin
            uopOp  = OP_LOAD;
            uopDst = gprN;
            uopSrc = gprM;
          end else begin
            uopOp  = OP_ADDI;
            uopDst = gprM;
            uopSrc = gprM;
            uopImm = IMM_WORD;
          end
        end
        CLS_RTE: begin
          case (step)
            STEP_W'(0): begin
              uopOp = OP_MOV;  uopDst = ID_TMP1; uopSrc = ID_SP;
            end
            STEP_W'(1): begin
              uopOp = OP_ADDI; uopDst = ID_TMP2; uopSrc = ID_SP;   uopImm = IMM_FRAME;
            end
            STEP_W'(2): begin
              uopOp = OP_ADDI; uopDst = ID_TMP3; uopSrc = ID_TMP1; uopImm = IMM_WORD;
            end
            STEP_W'(3): begin
              uopOp = OP_LOAD; uopDst = ID_SR;   uopSrc = ID_TMP3;
            end
            STEP_W'(4): begin
              uopOp = OP_MOV;  uopDst = ID_SP;   uopSrc = ID_TMP2;
            end
            default: begin
              uopOp = OP_LOAD; uopDst = ID_PC;   uopSrc = ID_TMP1;
            end
          endcase
        end
        default: begin
          uopOp  = OP_PASS;
          uopDst = gprN;
          uopSrc = gprM;
        end
      endcase
    end
  end

  assign uopValid = active;
  assign uopLast  = isLast;
  assign uopPc    = active ? heldPc : '0;

  // R6
  pc_write_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && uopDst == ID_PC) |-> uopLast);

  // R3
  addr_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && uopOp == OP_ADDI && !uopDst[REG_ID_W-1])
      |-> ($past(uopValid) && $past(uopOp) == OP_LOAD));

  // R7
  parent_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && !uopLast && !seqStb.clear) |=> (uopValid && $stable(uopPc)));

  // R5
  shadow_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && uopDst[REG_ID_W-1] && uopDst != ID_SR && uopDst != ID_PC) |-> !uopLast);

endmodule

// File: rtl/uop_split_decoder.sv
module uop_split_decoder
  import uop_seq_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int IMM_W        = 8,
  parameter int ACCESS_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             inValid,
  input  logic [1:0]       inClass,
  input  logic [3:0]       inRn,
  input  logic [3:0]       inRm,
  input  logic [PC_W-1:0]  inPc,
  output logic             stallFetch,
  output logic             uopValid,
  output logic [1:0]       uopOp,
  output logic [4:0]       uopDst,
  output logic [4:0]       uopSrc,
  output logic [IMM_W-1:0] uopImm,
  output logic [PC_W-1:0]  uopPc,
  output logic             uopLast
);

  seq_strobe_t       seqStb;
  logic              active;
  logic              isLast;
  logic [STEP_W-1:0] step;

  uop_seq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .inValid    (inValid),
    .inClass    (inClass),
    .inRn       (inRn),
    .inRm       (inRm),
    .seqStb     (seqStb),
    .active     (active),
    .step       (step),
    .isLast     (isLast),
    .stallFetch (stallFetch)
  );

  uop_seq_dpath #(
    .PC_W         (PC_W),
    .IMM_W        (IMM_W),
    .ACCESS_BYTES (ACCESS_BYTES)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .seqStb   (seqStb),
    .active   (active),
    .isLast   (isLast),
    .step     (step),
    .inClass  (inClass),
    .inRn     (inRn),
    .inRm     (inRm),
    .inPc     (inPc),
    .uopValid (uopValid),
    .uopOp    (uopOp),
    .uopDst   (uopDst),
    .uopSrc   (uopSrc),
    .uopImm   (uopImm),
    .uopPc    (uopPc),
    .uopLast  (uopLast)
  );

endmodule

// File: tb/test_uop_split_decoder.sv
module test_uop_split_decoder;

  localparam int PC_W = 32;
  localparam int IMM_W = 8;
  localparam int AB = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] inClass = '0;
  logic [3:0] inRn = '0;
  logic [3:0] inRm = '0;
  logic [PC_W-1:0] inPc = '0;
  logic stallFetch, uopValid, uopLast;
  logic [1:0] uopOp;
  logic [4:0] uopDst, uopSrc;
  logic [IMM_W-1:0] uopImm;
  logic [PC_W-1:0] uopPc;

  always #2.5 clk = ~clk;

  uop_split_decoder #(.PC_W(PC_W), .IMM_W(IMM_W), .ACCESS_BYTES(AB)) i_uop_split_decoder (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid), .inClass(inClass),
    .inRn(inRn), .inRm(inRm), .inPc(inPc), .stallFetch(stallFetch), .uopValid(uopValid),
    .uopOp(uopOp), .uopDst(uopDst), .uopSrc(uopSrc), .uopImm(uopImm), .uopPc(uopPc),
    .uopLast(uopLast)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected micro-op: {op, dst, src, imm, pc}
  typedef logic [2+5+5+IMM_W+PC_W-1:0] exp_t;
  exp_t  expQ[$];
  string tagQ[$];
  string ctlTag = "R1";
  bit    accepted;

  function automatic exp_t mk(int op, int dst, int src, int imm, logic [PC_W-1:0] pc);
    return {2'(op), 5'(dst), 5'(src), IMM_W'(imm), pc};
  endfunction

  task automatic check(bit ok, string tag, exp_t act, exp_t exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expand(int cls, int rn, int rm, logic [PC_W-1:0] pc, string firstTag);
    int n0 = expQ.size();
    if (cls == 1) begin
      // R3 load first, then address update; R4 same register suppresses update
      expQ.push_back(mk(3, rn, rm, 0, pc));
      tagQ.push_back(rn == rm ? "R4" : "R3");
      if (rn != rm) begin
        expQ.push_back(mk(2, rm, rm, AB, pc));
        tagQ.push_back("R3");
      end
    end else if (cls == 2) begin
      // R5 return-from-exception order
      expQ.push_back(mk(1, 16, 15, 0, pc));
      expQ.push_back(mk(2, 17, 15, 2 * AB, pc));
      expQ.push_back(mk(2, 18, 16, AB, pc));
      expQ.push_back(mk(3, 30, 18, 0, pc));
      expQ.push_back(mk(1, 15, 17, 0, pc));
      expQ.push_back(mk(3, 31, 16, 0, pc));
      for (int i = 0; i < 6; i++) tagQ.push_back("R5");
    end else begin
      // R2 plain pass-through
      expQ.push_back(mk(0, rn, rm, 0, pc));
      tagQ.push_back("R2");
    end
    if (firstTag != "") tagQ[n0] = firstTag;
  endtask

  // one cycle: compare at negedge, drive, then advance the model at posedge
  task automatic cyc(bit r, bit v, int cls, int rn, int rm, logic [PC_W-1:0] pc, bit fl);
    bit stallM, lastM;
    @(negedge clk);
    stallM = expQ.size() > 1;
    check(uopValid == (expQ.size() > 0) && stallFetch == stallM, ctlTag,
          exp_t'({uopValid, stallFetch}), exp_t'({expQ.size() > 0, stallM}));
    if (expQ.size() > 0) begin
      lastM = expQ.size() == 1;
      check({uopOp, uopDst, uopSrc, uopImm, uopPc} == expQ[0] && uopLast == lastM, tagQ[0],
            {uopOp, uopDst, uopSrc, uopImm, uopPc}, expQ[0]);
      // R6 PC destination only on the last micro-op
      if (uopDst == 5'd31) check(uopLast, "R6", exp_t'(uopLast), exp_t'(1));
    end
    rstN = r; inValid = v; inClass = 2'(cls); inRn = 4'(rn); inRm = 4'(rm); inPc = pc; flush = fl;
    @(posedge clk);
    accepted = 1'b0;
    ctlTag = "R7";
    if (!r) begin
      expQ.delete(); tagQ.delete(); ctlTag = "R1";
    end else if (fl) begin
      expQ.delete(); tagQ.delete(); ctlTag = "R8";
    end else begin
      bit wasLast = expQ.size() == 1;
      if (expQ.size() > 0) begin void'(expQ.pop_front()); void'(tagQ.pop_front()); end
      if (v && !stallM) begin
        accepted = 1'b1;
        // R9 back-to-back acceptance while the last micro-op is shown
        expand(cls, rn, rm, pc, wasLast ? "R9" : "");
      end
    end
  endtask

  task automatic issue(int cls, int rn, int rm, logic [PC_W-1:0] pc);
    do cyc(1, 1, cls, rn, rm, pc, 0); while (!accepted);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, '0, 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) cyc(0, 1, 2, 1, 2, 32'h40, 0);  // R1 inputs ignored in reset
    idle(2);
    issue(0, 3, 5, 32'h100); idle(2);          // R2
    issue(3, 9, 1, 32'h104); idle(2);          // R2 class 3
    issue(1, 2, 7, 32'h108); idle(3);          // R3
    issue(1, 4, 4, 32'h10c); idle(2);          // R4
    issue(2, 0, 0, 32'h200); idle(7);          // R5 R6
    issue(2, 0, 0, 32'h300);                   // R7 held instruction during stall
    issue(1, 6, 8, 32'h304);                   // R9 follows without bubble
    issue(0, 1, 1, 32'h308); idle(3);
    issue(2, 0, 0, 32'h400); idle(1);
    cyc(1, 1, 0, 7, 7, 32'h404, 1);            // R8 flush drops offered instruction
    idle(1);
    issue(2, 0, 0, 32'h500); idle(7);          // R8 restart from first micro-op
    for (int i = 0; i < 600; i++)
      cyc(1, 1'($urandom % 2), int'($urandom % 4), int'($urandom % 16), int'($urandom % 16),
          32'($urandom), ($urandom % 16) == 0);
    idle(8);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule